// File: doc/BRIEF.md
# Link Turnaround and Timeout Controller

This block sits beside the low-power command path of a serial display host. It watches each packet as the transmitter finishes it. When that packet expects an answer from the panel (a read request, or a short display-command write that switches on the tearing-effect signal), the block waits a programmable number of escape-clock ticks. It then asks the PHY to hand bus ownership to the peripheral. The request is held until the PHY acknowledges the direction change or a turnaround timer expires.

Two further timers run on their own. A receive watchdog measures how long the PHY reports low-power receive mode without valid data. A PLL settling counter runs in system clocks after a start pulse and then reports a stable clock. Events land in sticky interrupt bits that are cleared by writing one.

All escape-clock timing uses a one-cycle enable pulse inside the single system clock domain.

Top module: `dsi_bta_ctrl`

## Requirements
- R1: While reset is held and on its release, bta_req_o, bta_busy_o, pll_stable_o and all three irq_o bits are 0.
- R2: A finished packet starts a turnaround sequence (bta_busy_o rises after the capturing edge) in two cases. The first is a 6-bit type code of 0x04, 0x14, 0x24 or 0x06. The second is a type of 0x05 or 0x15 whose command byte is 0x35.
- R3: Every other packet leaves bta_busy_o at 0. This includes type 0x37, and types 0x05 or 0x15 carrying any other command byte.
- R4: After a start, bta_req_o rises on the first clock edge at which the hold counter, loaded with hold_cnt_i, has already been decremented to zero. One escape tick decrements it once. A hold of 0 raises bta_req_o on the edge after the capturing edge. bta_req_o implies bta_busy_o.
- R5: Qualifying packets that finish while bta_busy_o is 1 are ignored and do not queue a second turnaround.
- R6: dir_ack_i sampled high while bta_req_o is 1 drops bta_req_o and bta_busy_o on that edge and sets no interrupt.
- R7: Without acknowledgement, the turnaround counter loaded with bta_to_i is decremented by each tick. The tick that finds it at zero (the bta_to_i+1-th) sets irq_o[0] and ends the sequence.
- R8: While rx_lpdt_i is 1 and rx_valid_i is 0, ticks decrement a counter loaded with rx_to_i. The tick that finds zero sets irq_o[1], and it fires only once per window. rx_lpdt_i low or rx_valid_i high reloads the counter and re-arms it.
- R9: A pll_start_i pulse loads pll_time_i and clears pll_stable_o. System clocks then decrement the count. The edge that finds zero sets pll_stable_o and irq_o[2], so both rise pll_time_i+1 edges after the loading edge.
- R10: Interrupt bits stay set until the matching irq_clr_i bit is sampled high. A set on the same edge wins over the clear.
- R11: The hold, turnaround and receive counters move only on edges where esc_tick_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| esc_tick_i | input | 1 | One-cycle escape-clock enable |
| pkt_done_i | input | 1 | Transmitted packet finished this cycle |
| pkt_type_i | input | 6 | Data type of the finished packet |
| pkt_cmd_i | input | 8 | First payload byte (display command) |
| hold_cnt_i | input | HOLD_W | Ticks between packet end and turnaround request |
| bta_to_i | input | BTA_W | Turnaround timeout in ticks |
| rx_to_i | input | RX_W | Receive window timeout in ticks |
| pll_time_i | input | PLL_W | PLL settling time in system clocks |
| pll_start_i | input | 1 | Loads and starts the PLL timer |
| dir_ack_i | input | 1 | PHY reports the direction change |
| rx_lpdt_i | input | 1 | PHY is in low-power receive mode |
| rx_valid_i | input | 1 | PHY receive data valid |
| irq_clr_i | input | 3 | Write-one-to-clear for irq_o |
| bta_req_o | output | 1 | Turnaround request to the PHY |
| bta_busy_o | output | 1 | Hold or turnaround in progress |
| pll_stable_o | output | 1 | PLL settling time elapsed |
| irq_o | output | 3 | Sticky interrupts: 0 turnaround timeout, 1 receive timeout, 2 PLL stable |

## Verification
Several properties are checked on every cycle. The request never stands without the busy flag. The request holds steady across cycles with no tick and no acknowledgement. An acknowledgement always drops the request. A turnaround-timeout interrupt only rises as a pending request falls. Interrupt bits persist until cleared. The exact counts of the hold, the timeouts and the PLL settling time, the packet classification, and the rejection of packets during a busy sequence can only be shown by the bench's scenarios, which compare every cycle against a behavioural model.

// File: rtl/dsi_bta_pkg.sv
package dsi_bta_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_HOLD, SEQ_TURN} seq_state_e;

  localparam int IRQ_N   = 3;
  localparam int IRQ_BTA = 0;
  localparam int IRQ_RX  = 1;
  localparam int IRQ_PLL = 2;

  localparam logic [5:0] DT_GEN_RD0  = 6'h04;
  localparam logic [5:0] DT_GEN_RD1  = 6'h14;
  localparam logic [5:0] DT_GEN_RD2  = 6'h24;
  localparam logic [5:0] DT_DCS_RD   = 6'h06;
  localparam logic [5:0] DT_DCS_WR0  = 6'h05;
  localparam logic [5:0] DT_DCS_WR1  = 6'h15;
  localparam logic [7:0] CMD_TEAR_ON = 8'h35;
endpackage

// File: rtl/dsi_pkt_classify.sv
module dsi_pkt_classify
  import dsi_bta_pkg::*;
(
  input  logic [5:0] type_i,
  input  logic [7:0] cmd_i,
  output logic       needs_bta_o
);
  logic is_read, is_tear;

  always_comb begin
    is_read = (type_i == DT_GEN_RD0) || (type_i == DT_GEN_RD1) ||
              (type_i == DT_GEN_RD2) || (type_i == DT_DCS_RD);
    is_tear = ((type_i == DT_DCS_WR0) || (type_i == DT_DCS_WR1)) &&
              (cmd_i == CMD_TEAR_ON);
    needs_bta_o = is_read || is_tear;
  end
endmodule

// File: rtl/dsi_bta_seq.sv
module dsi_bta_seq
  import dsi_bta_pkg::*;
#(
  parameter int HOLD_W = 16,
  parameter int BTA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] hold_cnt_i,
  input  logic [BTA_W-1:0]  bta_to_i,
  input  logic              dir_ack_i,
  output logic              req_o,
  output logic              busy_o,
  output logic              timeout_o
);
  localparam logic [HOLD_W-1:0] HOLD_ONE = HOLD_W'(1);
  localparam logic [BTA_W-1:0]  BTA_ONE  = BTA_W'(1);

  seq_state_e        st_q;
  logic [HOLD_W-1:0] hold_q;
  logic [BTA_W-1:0]  turn_q;

  // expiry is combinational so the interrupt lands on the edge that ends the turn
  assign timeout_o = (st_q == SEQ_TURN) && !dir_ack_i && tick_i && (turn_q == '0);
  assign req_o     = (st_q == SEQ_TURN);
  assign busy_o    = (st_q != SEQ_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      hold_q <= '0;
      turn_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (start_i) begin
          st_q   <= SEQ_HOLD;
          hold_q <= hold_cnt_i;
        end
        SEQ_HOLD: if (hold_q == '0) begin
          st_q   <= SEQ_TURN;
          turn_q <= bta_to_i;
        end else if (tick_i) begin
          hold_q <= hold_q - HOLD_ONE;
        end
        SEQ_TURN: if (dir_ack_i) begin
          st_q <= SEQ_IDLE;
        end else if (tick_i) begin
          if (turn_q == '0) st_q <= SEQ_IDLE;
          else              turn_q <= turn_q - BTA_ONE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsi_rx_watch.sv
module dsi_rx_watch #(
  parameter int RX_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            lpdt_i,
  input  logic            valid_i,
  input  logic [RX_W-1:0] rx_to_i,
  output logic            timeout_o
);
  localparam logic [RX_W-1:0] RX_ONE = RX_W'(1);

  logic [RX_W-1:0] cnt_q;
  logic            fired_q;
  logic            waiting;

  assign waiting   = lpdt_i && !valid_i;
  assign timeout_o = waiting && tick_i && !fired_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (!waiting) begin
      cnt_q   <= rx_to_i;
      fired_q <= 1'b0;
    end else if (tick_i && !fired_q) begin
      if (cnt_q == '0) fired_q <= 1'b1;
      else             cnt_q   <= cnt_q - RX_ONE;
    end
  end
endmodule

// File: rtl/dsi_pll_timer.sv
module dsi_pll_timer #(
  parameter int PLL_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PLL_W-1:0] time_i,
  output logic             stable_o,
  output logic             done_o
);
  localparam logic [PLL_W-1:0] PLL_ONE = PLL_W'(1);

  logic [PLL_W-1:0] cnt_q;
  logic             run_q;

  assign done_o = run_q && !start_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      run_q    <= 1'b0;
      stable_o <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= time_i;
      run_q    <= 1'b1;
      stable_o <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_q    <= 1'b0;
        stable_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - PLL_ONE;
      end
    end
  end
endmodule

// File: rtl/dsi_bta_ctrl.sv
module dsi_bta_ctrl
  import dsi_bta_pkg::*;
#(
  parameter int HOLD_W = 16,
  parameter int BTA_W  = 8,
  parameter int RX_W   = 16,
  parameter int PLL_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              esc_tick_i,
  input  logic              pkt_done_i,
  input  logic [5:0]        pkt_type_i,
  input  logic [7:0]        pkt_cmd_i,
  input  logic [HOLD_W-1:0] hold_cnt_i,
  input  logic [BTA_W-1:0]  bta_to_i,
  input  logic [RX_W-1:0]   rx_to_i,
  input  logic [PLL_W-1:0]  pll_time_i,
  input  logic              pll_start_i,
  input  logic              dir_ack_i,
  input  logic              rx_lpdt_i,
  input  logic              rx_valid_i,
  input  logic [IRQ_N-1:0]  irq_clr_i,
  output logic              bta_req_o,
  output logic              bta_busy_o,
  output logic              pll_stable_o,
  output logic [IRQ_N-1:0]  irq_o
);
  logic             needs_bta;
  logic [IRQ_N-1:0] irq_set;

  dsi_pkt_classify u_classify (
    .type_i      (pkt_type_i),
    .cmd_i       (pkt_cmd_i),
    .needs_bta_o (needs_bta)
  );

  dsi_bta_seq #(.HOLD_W(HOLD_W), .BTA_W(BTA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (esc_tick_i),
    .start_i    (pkt_done_i && needs_bta),
    .hold_cnt_i (hold_cnt_i),
    .bta_to_i   (bta_to_i),
    .dir_ack_i  (dir_ack_i),
    .req_o      (bta_req_o),
    .busy_o     (bta_busy_o),
    .timeout_o  (irq_set[IRQ_BTA])
  );

  dsi_rx_watch #(.RX_W(RX_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (esc_tick_i),
    .lpdt_i    (rx_lpdt_i),
    .valid_i   (rx_valid_i),
    .rx_to_i   (rx_to_i),
    .timeout_o (irq_set[IRQ_RX])
  );

  dsi_pll_timer #(.PLL_W(PLL_W)) u_pll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (pll_start_i),
    .time_i   (pll_time_i),
    .stable_o (pll_stable_o),
    .done_o   (irq_set[IRQ_PLL])
  );

  for (genvar k = 0; k < IRQ_N; k++) begin : g_irq
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[k] <= 1'b0;
      else         irq_o[k] <= irq_set[k] | (irq_o[k] & ~irq_clr_i[k]);
    end
  end
endmodule

// File: rtl/dsi_bta_ctrl_chk.sv
module dsi_bta_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       esc_tick_i,
  input logic       dir_ack_i,
  input logic [2:0] irq_clr_i,
  input logic       bta_req_o,
  input logic       bta_busy_o,
  input logic       pll_stable_o,
  input logic [2:0] irq_o
);
  assert_req_in_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bta_req_o |-> bta_busy_o);

  assert_ack_drops_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bta_req_o && dir_ack_i |=> !bta_req_o);

  assert_timeout_ends_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> $past(bta_req_o) && !bta_req_o);

  assert_req_holds_no_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bta_req_o && !esc_tick_i && !dir_ack_i |=> bta_req_o);

  assert_stable_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_stable_o) |-> irq_o[2]);

  assert_irq_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[1] && !irq_clr_i[1] |=> irq_o[1]);
endmodule

bind dsi_bta_ctrl dsi_bta_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .esc_tick_i   (esc_tick_i),
  .dir_ack_i    (dir_ack_i),
  .irq_clr_i    (irq_clr_i),
  .bta_req_o    (bta_req_o),
  .bta_busy_o   (bta_busy_o),
  .pll_stable_o (pll_stable_o),
  .irq_o        (irq_o)
);

// File: tb/dsi_bta_ctrl_bench.sv
`timescale 1ns/1ps
module dsi_bta_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        esc_tick = 1'b0;
  logic        pkt_done = 1'b0;
  logic [5:0]  pkt_type = '0;
  logic [7:0]  pkt_cmd = '0;
  logic [15:0] hold_cnt = '0;
  logic [7:0]  bta_to = '0;
  logic [15:0] rx_to = '0;
  logic [19:0] pll_time = '0;
  logic        pll_start = 1'b0;
  logic        dir_ack = 1'b0;
  logic        rx_lpdt = 1'b0;
  logic        rx_valid = 1'b0;
  logic [2:0]  irq_clr = '0;
  logic        bta_req, bta_busy, pll_stable;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit tick_en = 1'b1;
  int tdiv = 0;

  always #4 clk = ~clk;

  dsi_bta_ctrl u_dsi_bta_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .esc_tick_i(esc_tick),
    .pkt_done_i(pkt_done), .pkt_type_i(pkt_type), .pkt_cmd_i(pkt_cmd),
    .hold_cnt_i(hold_cnt), .bta_to_i(bta_to), .rx_to_i(rx_to),
    .pll_time_i(pll_time), .pll_start_i(pll_start), .dir_ack_i(dir_ack),
    .rx_lpdt_i(rx_lpdt), .rx_valid_i(rx_valid), .irq_clr_i(irq_clr),
    .bta_req_o(bta_req), .bta_busy_o(bta_busy), .pll_stable_o(pll_stable),
    .irq_o(irq)
  );

  // escape tick: one cycle in four
  always @(negedge clk) begin
    tdiv = tdiv + 1;
    esc_tick = tick_en && (tdiv % 4 == 3);
  end

  // behavioural reference
  int m_st, m_hold, m_turn, m_rx, m_pll;
  bit m_rxf, m_run, m_stab;
  bit [2:0] m_irq;

  always @(posedge clk or negedge rst_n) begin : model
    int t;
    bit trg;
    bit [2:0] s;
    if (!rst_n) begin
      m_st = 0; m_hold = 0; m_turn = 0; m_rx = 0; m_pll = 0;
      m_rxf = 0; m_run = 0; m_stab = 0; m_irq = '0;
    end else begin
      s = '0;
      t = int'(pkt_type);
      trg = pkt_done && (t == 'h04 || t == 'h14 || t == 'h24 || t == 'h06 ||
            ((t == 'h05 || t == 'h15) && pkt_cmd == 8'h35));
      if (m_st == 0) begin
        if (trg) begin m_st = 1; m_hold = int'(hold_cnt); end
      end else if (m_st == 1) begin
        if (m_hold == 0) begin m_st = 2; m_turn = int'(bta_to); end
        else if (esc_tick) m_hold = m_hold - 1;
      end else begin
        if (dir_ack) m_st = 0;
        else if (esc_tick) begin
          if (m_turn == 0) begin m_st = 0; s[0] = 1; end
          else m_turn = m_turn - 1;
        end
      end
      if (!rx_lpdt || rx_valid) begin m_rx = int'(rx_to); m_rxf = 0; end
      else if (esc_tick && !m_rxf) begin
        if (m_rx == 0) begin m_rxf = 1; s[1] = 1; end
        else m_rx = m_rx - 1;
      end
      if (pll_start) begin m_pll = int'(pll_time); m_run = 1; m_stab = 0; end
      else if (m_run) begin
        if (m_pll == 0) begin m_run = 0; m_stab = 1; s[2] = 1; end
        else m_pll = m_pll - 1;
      end
      m_irq = (m_irq & ~irq_clr) | s;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(bta_req == (m_st == 2), "R4 bta_req_o vs model", int'(bta_req), int'(m_st == 2));
      chk(bta_busy == (m_st != 0), "R2 bta_busy_o vs model", int'(bta_busy), int'(m_st != 0));
      chk(irq == m_irq, "R10 irq_o vs model", int'(irq), int'(m_irq));
      chk(pll_stable == m_stab, "R9 pll_stable_o vs model", int'(pll_stable), int'(m_stab));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [5:0] ty, input logic [7:0] cm);
    @(negedge clk);
    pkt_done = 1'b1; pkt_type = ty; pkt_cmd = cm;
    @(negedge clk);
    pkt_done = 1'b0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 400 && !bta_req; i++) @(negedge clk);
  endtask

  task automatic ack();
    dir_ack = 1'b1;
    @(negedge clk);
    dir_ack = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    cyc(200000 - 50000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    cyc(3);
    chk(bta_req == 0 && bta_busy == 0, "R1 reset request/busy", int'({bta_req, bta_busy}), 0);
    chk(irq == 0 && pll_stable == 0, "R1 reset irq/stable", int'({irq, pll_stable}), 0);
    rst_n = 1'b1;
    cyc(2);
    chk(irq == 0 && bta_busy == 0, "R1 after release", int'({irq, bta_busy}), 0);

    hold_cnt = 3; bta_to = 5; rx_to = 2;
    send(6'h14, 8'h00);
    chk(bta_busy == 1 && bta_req == 0, "R2 read type 0x14 starts hold", int'({bta_busy, bta_req}), 2);
    wait_req();
    chk(bta_req == 1, "R4 request after hold", int'(bta_req), 1);
    ack();
    chk(bta_req == 0 && bta_busy == 0 && irq[0] == 0, "R6 ack ends turn", int'({bta_req, bta_busy, irq[0]}), 0);

    send(6'h37, 8'h00);
    chk(bta_busy == 0, "R3 max return size ignored", int'(bta_busy), 0);
    send(6'h15, 8'h36);
    chk(bta_busy == 0, "R3 other DCS write ignored", int'(bta_busy), 0);
    send(6'h39, 8'h35);
    chk(bta_busy == 0, "R3 long write ignored", int'(bta_busy), 0);

    send(6'h05, 8'h35);
    chk(bta_busy == 1, "R2 tear-on write starts", int'(bta_busy), 1);
    send(6'h06, 8'h00);
    cyc(80);
    chk(irq[0] == 1 && bta_req == 0, "R7 turnaround timeout", int'({irq[0], bta_req}), 2);
    chk(bta_busy == 0, "R5 busy-time read not queued", int'(bta_busy), 0);
    cyc(3);
    chk(irq[0] == 1, "R10 timeout irq sticky", int'(irq[0]), 1);
    irq_clr = 3'b001; @(negedge clk); irq_clr = '0;
    chk(irq[0] == 0, "R10 write-one clears", int'(irq[0]), 0);

    hold_cnt = 0;
    send(6'h24, 8'h00);
    @(negedge clk);
    chk(bta_req == 1, "R4 zero hold requests at once", int'(bta_req), 1);
    ack();

    tick_en = 1'b0; hold_cnt = 2;
    send(6'h04, 8'h00);
    cyc(30);
    chk(bta_busy == 1 && bta_req == 0, "R11 no tick keeps hold", int'({bta_busy, bta_req}), 2);
    tick_en = 1'b1;
    wait_req();
    chk(bta_req == 1, "R11 ticks resume hold", int'(bta_req), 1);
    ack();

    rx_lpdt = 1'b1; rx_valid = 1'b0;
    cyc(20);
    chk(irq[1] == 1, "R8 receive timeout", int'(irq[1]), 1);
    irq_clr = 3'b010; @(negedge clk); irq_clr = '0;
    cyc(20);
    chk(irq[1] == 0, "R8 fires once per window", int'(irq[1]), 0);
    rx_lpdt = 1'b0; @(negedge clk); rx_lpdt = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cyc(5); rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
    end
    chk(irq[1] == 0, "R8 valid reloads window", int'(irq[1]), 0);
    rx_lpdt = 1'b0;

    pll_time = 10;
    pll_start = 1'b1; @(negedge clk); pll_start = 1'b0;
    cyc(10);
    chk(pll_stable == 0, "R9 not stable early", int'(pll_stable), 0);
    cyc(1);
    chk(pll_stable == 1 && irq[2] == 1, "R9 stable after count", int'({pll_stable, irq[2]}), 3);
    pll_time = 3;
    pll_start = 1'b1; @(negedge clk); pll_start = 1'b0;
    chk(pll_stable == 0, "R9 restart clears stable", int'(pll_stable), 0);
    irq_clr = 3'b100;
    cyc(4);
    chk(irq[2] == 1, "R10 set wins over clear", int'(irq[2]), 1);
    @(negedge clk);
    chk(irq[2] == 0, "R10 clear after set", int'(irq[2]), 0);
    irq_clr = '0;
    cyc(5);
    summary();
  end
endmodule